// File: doc/BRIEF.md
# Search Branch Step Unit

This block carries out a single bit position of the bus enumeration search on a one-wire bus. It does not drive the wire itself. It asks an external slot generator for three time slots, one after another, through a pulse-and-acknowledge handshake. The first two are read slots. They return the true value of the current address bit and then its inverted copy, as the responding devices report them. The block then picks the branch to follow and asks for one write slot that carries the chosen direction.

A search controller above this block holds the address collected so far and the position of the last disagreement. For each bit it pulses `step_go` along with the direction it wants whenever devices disagree. It then waits for `step_done` and reads the 3-bit result. When both read slots return 1, no device is answering. In that case the block finishes without a write slot and reports an error code.

Top module: `search_step_unit`

## Requirements
- R1: After reset, `step_done`, `slot_go` and `step_status` are all zero and the unit is idle.
- R2: A `step_go` pulse received while idle makes `slot_go` high in the next cycle with `slot_rd` = 1, requesting the first read slot for the true bit. `want_dir` is captured in that same cycle and only that captured value is used.
- R3: The `slot_done` that ends the first read slot stores `slot_bit` as the true bit. In the next cycle the unit requests a second read slot (`slot_go` = 1, `slot_rd` = 1) for the inverted bit.
- R4: If both read slots return 1, no write slot is requested. `step_done` pulses in the cycle after the second read's `slot_done`, with `step_status` = 3'b011.
- R5: If both read slots return 0, a write slot (`slot_rd` = 0) is requested in the cycle after the second read's `slot_done`, with `slot_wbit` equal to the captured `want_dir`. The final status is 3'b100 when that direction is 1 and 3'b000 when it is 0.
- R6: If exactly one read slot returns 1, the write slot carries the true bit. The final status is 3'b101 when the true bit is 1 and 3'b010 when it is 0.
- R7: In every case without an error, `step_done` pulses for exactly one cycle, in the cycle after the write slot's `slot_done`. In every case, status bit 0 is the true bit, bit 1 is the inverted bit, and bit 2 is the direction taken.
- R8: `step_status` changes only in a cycle where `step_done` is high. It holds its value until the following step completes, even while that next step is under way.
- R9: `step_go` received while a step is in progress is ignored. `slot_done` received while idle is ignored and neither raises `step_done` nor alters `step_status`.
- R10: `slot_go` is a single-cycle pulse, and only one slot is outstanding at a time. No new request is issued until the current slot's `slot_done` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_go | input | 1 | Start one search step (pulse) |
| want_dir | input | 1 | Direction to take when devices disagree; sampled with `step_go` |
| slot_go | output | 1 | Single-cycle request to the slot generator |
| slot_rd | output | 1 | Slot kind with the request: 1 = read slot, 0 = write slot |
| slot_wbit | output | 1 | Bit value for a write slot |
| slot_done | input | 1 | Slot generator has finished the requested slot (pulse) |
| slot_bit | input | 1 | Level sampled by a read slot, valid with `slot_done` |
| step_done | output | 1 | Step finished; `step_status` updated in this cycle |
| step_status | output | 3 | {direction taken, inverted bit, true bit}; 3'b011 = no device |

## Verification
Two events can land in the same cycle: the completion of one step, where `step_done` is high and the status is being replaced, and the acceptance of the next `step_go`. The bench raises `step_go` in the cycle where it sees `step_done`. It then checks that a read request follows in the next cycle, and that the status from the step just finished stays unchanged until the new step ends. A second overlap is a `step_go` that arrives while the unit is waiting on a slot. The bench injects such pulses during the random slot latencies and judges them by the absence of any extra `slot_go` and by a correct final status.

// File: rtl/search_step_pkg.sv
package search_step_pkg;

    localparam int STAT_W   = 3;
    localparam int STAT_ID  = 0;
    localparam int STAT_CMP = 1;
    localparam int STAT_DIR = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_TRUE,
        ST_WAIT_INV,
        ST_WAIT_WRITE
    } step_state_e;

    typedef struct packed {
        step_state_e         state;
        logic                true_bit;
        logic                dir_pref;
        logic [STAT_W-1:0]   pend;
        logic [STAT_W-1:0]   status;
        logic                done;
        logic                seen_clk;
    } step_regs_t;

    typedef struct packed {
        logic go;
        logic rd;
        logic wbit;
    } slot_req_t;

endpackage

// File: rtl/search_step_decide.sv
module search_step_decide
    import search_step_pkg::*;
(
    input  logic              true_bit,
    input  logic              inv_bit,
    input  logic              dir_pref,
    output logic              no_device,
    output logic              dir,
    output logic [STAT_W-1:0] status
);
    always_comb begin
        no_device = true_bit & inv_bit;
        dir       = (true_bit ^ inv_bit) ? true_bit : dir_pref;
        status    = '0;
        if (no_device) begin
            status[STAT_ID]  = 1'b1;
            status[STAT_CMP] = 1'b1;
        end else begin
            status[STAT_ID]  = true_bit;
            status[STAT_CMP] = inv_bit;
            status[STAT_DIR] = dir;
        end
    end
endmodule

// File: rtl/search_step_slot_req.sv
module search_step_slot_req
    import search_step_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic issue_rd,
    input  logic issue_bit,
    output logic slot_go,
    output logic slot_rd,
    output logic slot_wbit
);
    slot_req_t req_d, req_q;

    always_comb begin
        req_d      = req_q;
        req_d.go   = issue;
        if (issue) begin
            req_d.rd   = issue_rd;
            req_d.wbit = issue_rd ? 1'b0 : issue_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign slot_go   = req_q.go;
    assign slot_rd   = req_q.rd;
    assign slot_wbit = req_q.wbit;

    a_r10_go_single: assert property (@(posedge clk) disable iff (!rst_n)
        slot_go |=> !slot_go);
endmodule

// File: rtl/search_step_unit.sv
module search_step_unit
    import search_step_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_go,
    input  logic              want_dir,
    output logic              slot_go,
    output logic              slot_rd,
    output logic              slot_wbit,
    input  logic              slot_done,
    input  logic              slot_bit,
    output logic              step_done,
    output logic [STAT_W-1:0] step_status
);
    step_regs_t r_d, r_q;

    logic              issue, issue_rd, issue_bit;
    logic              dec_nodev, dec_dir;
    logic [STAT_W-1:0] dec_status;

    search_step_decide u_decide (
        .true_bit  (r_q.true_bit),
        .inv_bit   (slot_bit),
        .dir_pref  (r_q.dir_pref),
        .no_device (dec_nodev),
        .dir       (dec_dir),
        .status    (dec_status)
    );

    search_step_slot_req u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .issue_rd  (issue_rd),
        .issue_bit (issue_bit),
        .slot_go   (slot_go),
        .slot_rd   (slot_rd),
        .slot_wbit (slot_wbit)
    );

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        r_d.seen_clk = 1'b1;
        issue        = 1'b0;
        issue_rd     = 1'b0;
        issue_bit    = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (step_go) begin
                    r_d.dir_pref = want_dir;
                    r_d.state    = ST_WAIT_TRUE;
                    issue        = 1'b1;
                    issue_rd     = 1'b1;
                end
            end
            ST_WAIT_TRUE: begin
                if (slot_done) begin
                    r_d.true_bit = slot_bit;
                    r_d.state    = ST_WAIT_INV;
                    issue        = 1'b1;
                    issue_rd     = 1'b1;
                end
            end
            ST_WAIT_INV: begin
                if (slot_done) begin
                    if (dec_nodev) begin
                        r_d.status = dec_status;
                        r_d.done   = 1'b1;
                        r_d.state  = ST_IDLE;
                    end else begin
                        r_d.pend   = dec_status;
                        r_d.state  = ST_WAIT_WRITE;
                        issue      = 1'b1;
                        issue_bit  = dec_dir;
                    end
                end
            end
            ST_WAIT_WRITE: begin
                if (slot_done) begin
                    r_d.status = r_q.pend;
                    r_d.done   = 1'b1;
                    r_d.state  = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign step_done   = r_q.done;
    assign step_status = r_q.status;

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !step_done);

    a_r2_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && step_go) |=> (slot_go && slot_rd));

    a_r4_error_code: assert property (@(posedge clk) disable iff (!rst_n)
        (step_done && step_status[STAT_ID] && step_status[STAT_CMP]) |-> !step_status[STAT_DIR]);

    a_r6_follow_true: assert property (@(posedge clk) disable iff (!rst_n)
        (step_done && (step_status[STAT_ID] ^ step_status[STAT_CMP]))
            |-> (step_status[STAT_DIR] == step_status[STAT_ID]));

    a_r8_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.seen_clk && !step_done) |-> $stable(step_status));

    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_go && !slot_done) |=> !slot_go);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && !step_go) |=> !slot_go);
endmodule

// File: tb/test_search_step_unit.sv
module test_search_step_unit;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       step_go, want_dir, slot_done, slot_bit;
    logic       slot_go, slot_rd, slot_wbit, step_done;
    logic [2:0] step_status;

    int total = 0;
    int bad   = 0;
    logic [2:0] last_status;

    always #5 clk = ~clk;

    search_step_unit i_search_step_unit (
        .clk(clk), .rst_n(rst_n), .step_go(step_go), .want_dir(want_dir),
        .slot_go(slot_go), .slot_rd(slot_rd), .slot_wbit(slot_wbit),
        .slot_done(slot_done), .slot_bit(slot_bit),
        .step_done(step_done), .step_status(step_status)
    );

    function automatic logic [2:0] exp_status(input logic t, input logic c, input logic p);
        if (t && c)      return 3'b011;
        else if (!t && !c) return {p, 2'b00};
        else             return {t, c, t};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge where a request is expected; returns one negedge after slot_done.
    task automatic serve(input bit exp_rd, input bit exp_wbit, input bit rbit,
                         input int lat, input bit poke, input string req);
        check(slot_go == 1'b1, req, slot_go, 1);
        check(slot_rd == exp_rd, req, slot_rd, exp_rd);
        if (!exp_rd) check(slot_wbit == exp_wbit, req, slot_wbit, exp_wbit);
        @(negedge clk);
        check(slot_go == 1'b0, "R10", slot_go, 0);
        for (int k = 0; k < lat; k++) begin
            step_go = poke && (k == 0);
            @(negedge clk);
            step_go = 1'b0;
            check(slot_go == 1'b0, "R9/R10", slot_go, 0);
        end
        slot_done = 1'b1;
        slot_bit  = rbit;
        @(negedge clk);
        slot_done = 1'b0;
        slot_bit  = 1'($urandom);
    endtask

    // Starts at a negedge; ends at the negedge where step_done is expected high.
    task automatic run_step(input bit t, input bit c, input bit p, input int maxlat, input bit poke);
        logic [2:0] e;
        e = exp_status(t, c, p);
        step_go  = 1'b1;
        want_dir = p;
        @(negedge clk);
        step_go  = 1'b0;
        want_dir = ~p;
        check(step_status == last_status, "R8", step_status, last_status);
        serve(1'b1, 1'b0, t, int'($urandom_range(maxlat)), poke, "R2");
        check(step_status == last_status, "R8", step_status, last_status);
        serve(1'b1, 1'b0, c, int'($urandom_range(maxlat)), poke, "R3");
        if (t && c) begin
            check(slot_go == 1'b0, "R4", slot_go, 0);
        end else begin
            serve(1'b0, e[2], 1'b0, int'($urandom_range(maxlat)), poke,
                  (!t && !c) ? "R5" : "R6");
        end
        check(step_done == 1'b1, "R7", step_done, 1);
        check(step_status == e, (t && c) ? "R4" : ((!t && !c) ? "R5" : "R6"), step_status, e);
        last_status = e;
    endtask

    task automatic settle();
        @(negedge clk);
        check(step_done == 1'b0, "R7", step_done, 0);
        check(step_status == last_status, "R8", step_status, last_status);
        check(slot_go == 1'b0, "R10", slot_go, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; step_go = 1'b0; want_dir = 1'b0; slot_done = 1'b0; slot_bit = 1'b0;
        last_status = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(step_done == 1'b0, "R1", step_done, 0);
        check(slot_go == 1'b0, "R1", slot_go, 0);
        check(step_status == 3'b000, "R1", step_status, 0);

        // R9: slot_done while idle is ignored
        slot_done = 1'b1; slot_bit = 1'b1;
        @(negedge clk);
        slot_done = 1'b0;
        settle();

        // directed corners: every read pair, both preferences
        run_step(1'b1, 1'b1, 1'b0, 2, 1'b0); settle();           // R4
        run_step(1'b0, 1'b0, 1'b1, 2, 1'b0); settle();           // R5
        run_step(1'b0, 1'b0, 1'b0, 0, 1'b0); settle();           // R5
        run_step(1'b1, 1'b0, 1'b0, 3, 1'b0); settle();           // R6
        run_step(1'b0, 1'b1, 1'b1, 3, 1'b0); settle();           // R6
        // R9: step_go while busy
        run_step(1'b0, 1'b0, 1'b1, 3, 1'b1); settle();
        // back-to-back: new start in the done cycle (R8, R2)
        run_step(1'b1, 1'b0, 1'b1, 1, 1'b0);
        run_step(1'b1, 1'b1, 1'b1, 1, 1'b0);
        run_step(1'b0, 1'b0, 1'b0, 1, 1'b0);
        settle();

        // random mix
        for (int n = 0; n < 60; n++) begin
            run_step(1'($urandom), 1'($urandom), 1'($urandom), 4, 1'($urandom));
            if ($urandom_range(1) == 0) settle();
        end
        settle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule